// File: doc/BRIEF.md
# Hashed Page Table Chain Lookup

This block turns a virtual page number into a physical frame number using a hashed page table with chaining. The table lives in internal registers. It holds a set of buckets and a pool of elements. A bucket is either empty or names the head element of its chain. Each element stores a virtual page number, a frame number, the index of the next element, and a flag that marks it as the last element of its chain.

A lookup begins when the requester offers a page number while the engine is idle. The engine folds the page number with XOR to choose a bucket. It reads that bucket, then visits one chain element per clock. At each element it compares the stored page number with the request. The walk ends in one of three ways:
- the stored page number matches, and the engine reports a hit with that element's frame number;
- the engine reaches an empty bucket or the last element of the chain, and reports a fault;
- the engine has examined as many elements as the bound allows, and reports a fault, so a chain that loops back on itself cannot hang the engine.

A write port fills buckets and elements. The engine ignores this port while a lookup is in progress.

Top module: `hpt_lookup`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and every bucket is empty, so any lookup faults.
- R2: The bucket index is the XOR fold of the page number: bucket bit j is the XOR of every page number bit i with i mod BKT_W equal to j.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both 1. A match in the k-th element of the chain gives resp_valid with resp_hit=1 and that element's frame number on resp_pfn. This happens k+1 clock edges after the accepting edge.
- R4: When several page numbers share a bucket, the engine follows the next-element links and returns the frame number of the element whose stored page number equals the request.
- R5: A lookup that lands on an empty bucket gives resp_fault=1, one clock edge after the accepting edge.
- R6: A chain of L elements with no match ends in a fault on its last element (last flag = 1), L+1 clock edges after the accepting edge.
- R7: If MAX_WALK elements have been examined with no match and no last flag, the lookup ends in a fault MAX_WALK+1 clock edges after the accepting edge.
- R8: resp_valid lasts exactly one cycle. While it is 1, exactly one of resp_hit or resp_fault is 1, and resp_pfn is 0 on a fault.
- R9: req_ready is 0 from the accepting edge until the response cycle has ended. It is 1 again in the cycle that follows the response.
- R10: Writes presented while req_ready is 0 change nothing. A later lookup sees the table exactly as it was before the ignored write.
- R11: Writes apply on a clock edge with wr_en=1 and req_ready=1. With wr_is_elem=0, bucket wr_addr[BKT_W-1:0] takes valid=wr_flag and head=wr_link. With wr_is_elem=1, element wr_addr takes page number wr_vpn, frame wr_pfn, next=wr_link and last=wr_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request offered |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ready | output | 1 | Engine idle; a request is accepted on this edge |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Translation found |
| resp_fault | output | 1 | No translation (empty bucket, chain end, or walk bound) |
| resp_pfn | output | PFN_W | Frame number on a hit, zero on a fault |
| wr_en | input | 1 | Table write strobe |
| wr_is_elem | input | 1 | 1 writes an element, 0 writes a bucket |
| wr_addr | input | ADDR_W | Element index, or bucket index in the low BKT_W bits |
| wr_vpn | input | VPN_W | Stored page number for an element write |
| wr_pfn | input | PFN_W | Stored frame number for an element write |
| wr_link | input | ELEM_W | Next-element index, or the bucket's head index |
| wr_flag | input | 1 | Last-element flag, or the bucket's valid flag |

## Verification
The assertions assume three things about the table and the requester:
- the requester does not expect a new request to be taken before the response cycle has passed;
- any chain the table holds is either terminated by a last flag or is cut off by the walk bound;
- element contents are defined wherever a valid bucket points.

The stimulus keeps within these assumptions in the following ways. The write port is used only while the engine is idle, except in the one test that deliberately writes during a walk. Every bucket is given a valid head only after the elements it points to have been written. Each request is held for a single accepting edge, and the next request is not raised until the previous response has been observed. The looping chain is built on purpose, so that the bound is exercised through a legitimate table state.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUCKET = 2'd1,
        ST_WALK   = 2'd2,
        ST_RESP   = 2'd3
    } walk_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int VPN_W = 16,
    parameter int BKT_W = 4
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [BKT_W-1:0] bkt
);
    always_comb begin
        bkt = '0;
        for (int i = 0; i < VPN_W; i++) begin
            bkt[i % BKT_W] = bkt[i % BKT_W] ^ vpn[i];
        end
    end
endmodule

// File: rtl/hpt_store.sv
module hpt_store #(
    parameter int VPN_W  = 16,
    parameter int PFN_W  = 12,
    parameter int BKT_W  = 4,
    parameter int ELEM_W = 5,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wr_en,
    input  logic              wr_is_elem,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ELEM_W-1:0] wr_link,
    input  logic              wr_flag,
    input  logic [BKT_W-1:0]  rd_bkt,
    output logic              rd_bkt_valid,
    output logic [ELEM_W-1:0] rd_bkt_head,
    input  logic [ELEM_W-1:0] rd_elem,
    output logic [VPN_W-1:0]  rd_e_vpn,
    output logic [PFN_W-1:0]  rd_e_pfn,
    output logic [ELEM_W-1:0] rd_e_next,
    output logic              rd_e_last
);
    localparam int NUM_BKT  = 1 << BKT_W;
    localparam int NUM_ELEM = 1 << ELEM_W;

    logic              bkt_vld_q  [NUM_BKT];
    logic [ELEM_W-1:0] bkt_head_q [NUM_BKT];
    logic [VPN_W-1:0]  el_vpn_q   [NUM_ELEM];
    logic [PFN_W-1:0]  el_pfn_q   [NUM_ELEM];
    logic [ELEM_W-1:0] el_next_q  [NUM_ELEM];
    logic              el_last_q  [NUM_ELEM];

    logic [BKT_W-1:0]  wb_idx;
    logic [ELEM_W-1:0] we_idx;
    logic              wr_ok;

    assign wb_idx = wr_addr[BKT_W-1:0];
    assign we_idx = wr_addr[ELEM_W-1:0];
    assign wr_ok  = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BKT; b++) begin
                bkt_vld_q[b]  <= 1'b0;
                bkt_head_q[b] <= '0;
            end
            for (int e = 0; e < NUM_ELEM; e++) begin
                el_vpn_q[e]  <= '0;
                el_pfn_q[e]  <= '0;
                el_next_q[e] <= '0;
                el_last_q[e] <= 1'b1;
            end
        end else if (wr_ok) begin
            if (wr_is_elem) begin
                el_vpn_q[we_idx]  <= wr_vpn;
                el_pfn_q[we_idx]  <= wr_pfn;
                el_next_q[we_idx] <= wr_link;
                el_last_q[we_idx] <= wr_flag;
            end else begin
                bkt_vld_q[wb_idx]  <= wr_flag;
                bkt_head_q[wb_idx] <= wr_link;
            end
        end
    end

    assign rd_bkt_valid = bkt_vld_q[rd_bkt];
    assign rd_bkt_head  = bkt_head_q[rd_bkt];
    assign rd_e_vpn     = el_vpn_q[rd_elem];
    assign rd_e_pfn     = el_pfn_q[rd_elem];
    assign rd_e_next    = el_next_q[rd_elem];
    assign rd_e_last    = el_last_q[rd_elem];

    AST_BUSY_BKT_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !wr_is_elem) |=> (bkt_vld_q[$past(wb_idx)] == $past(bkt_vld_q[wb_idx]))) // R10
        else $error("bucket changed by a write while busy");
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int VPN_W    = 16,
    parameter int PFN_W    = 12,
    parameter int ELEM_W   = 5,
    parameter int MAX_WALK = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    output logic              req_ready,
    output logic              busy,
    output logic [VPN_W-1:0]  vpn_q,
    input  logic              bkt_valid,
    input  logic [ELEM_W-1:0] bkt_head,
    output logic [ELEM_W-1:0] elem_idx,
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic [PFN_W-1:0]  e_pfn,
    input  logic [ELEM_W-1:0] e_next,
    input  logic              e_last,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fault,
    output logic [PFN_W-1:0]  resp_pfn
);
    localparam int CNT_W = $clog2(MAX_WALK + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MAX_WALK - 1);

    walk_state_e       state_q;
    logic [ELEM_W-1:0] ptr_q;
    logic [CNT_W-1:0]  step_q;
    logic              hit_q;
    logic [PFN_W-1:0]  pfn_q;
    logic              match;

    assign match = (e_vpn == vpn_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            ptr_q   <= '0;
            step_q  <= '0;
            hit_q   <= 1'b0;
            pfn_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vpn_q   <= req_vpn;
                        state_q <= ST_BUCKET;
                    end
                end
                ST_BUCKET: begin
                    if (!bkt_valid) begin
                        hit_q   <= 1'b0;
                        pfn_q   <= '0;
                        state_q <= ST_RESP;
                    end else begin
                        ptr_q   <= bkt_head;
                        step_q  <= '0;
                        state_q <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    step_q <= step_q + 1'b1;
                    if (match) begin
                        hit_q   <= 1'b1;
                        pfn_q   <= e_pfn;
                        state_q <= ST_RESP;
                    end else if (e_last || (step_q == LAST_STEP)) begin
                        hit_q   <= 1'b0;
                        pfn_q   <= '0;
                        state_q <= ST_RESP;
                    end else begin
                        ptr_q <= e_next;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign busy       = !req_ready;
    assign elem_idx   = ptr_q;
    assign resp_valid = (state_q == ST_RESP);
    assign resp_hit   = resp_valid && hit_q;
    assign resp_fault = resp_valid && !hit_q;
    assign resp_pfn   = resp_valid ? pfn_q : '0;

    AST_WALK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WALK) |-> (step_q < CNT_W'(MAX_WALK))) // R7
        else $error("walk exceeded bound");

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid) // R8
        else $error("response longer than one cycle");

    AST_FAULT_NO_PFN: assert property (@(posedge clk) disable iff (rst)
        resp_fault |-> (resp_pfn == '0)) // R8
        else $error("fault carries a frame number");

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready) // R9
        else $error("ready stayed high after accept");

    AST_HIT_MATCHES: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> $past(e_vpn == vpn_q)) // R4
        else $error("hit without matching element");
endmodule

// File: rtl/hpt_lookup.sv
module hpt_lookup
    import hpt_pkg::*;
#(
    parameter int VPN_W    = 16,
    parameter int PFN_W    = 12,
    parameter int BKT_W    = 4,
    parameter int ELEM_W   = 5,
    parameter int MAX_WALK = 8,
    parameter int ADDR_W   = max_of(BKT_W, ELEM_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fault,
    output logic [PFN_W-1:0]  resp_pfn,
    input  logic              wr_en,
    input  logic              wr_is_elem,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ELEM_W-1:0] wr_link,
    input  logic              wr_flag
);
    logic              busy;
    logic [VPN_W-1:0]  vpn_q;
    logic [BKT_W-1:0]  bkt_sel;
    logic              bkt_valid;
    logic [ELEM_W-1:0] bkt_head;
    logic [ELEM_W-1:0] elem_idx;
    logic [VPN_W-1:0]  e_vpn;
    logic [PFN_W-1:0]  e_pfn;
    logic [ELEM_W-1:0] e_next;
    logic              e_last;

    hpt_hash #(.VPN_W(VPN_W), .BKT_W(BKT_W)) u_hash (
        .vpn (vpn_q),
        .bkt (bkt_sel)
    );

    hpt_store #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .BKT_W(BKT_W),
        .ELEM_W(ELEM_W), .ADDR_W(ADDR_W)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .busy         (busy),
        .wr_en        (wr_en),
        .wr_is_elem   (wr_is_elem),
        .wr_addr      (wr_addr),
        .wr_vpn       (wr_vpn),
        .wr_pfn       (wr_pfn),
        .wr_link      (wr_link),
        .wr_flag      (wr_flag),
        .rd_bkt       (bkt_sel),
        .rd_bkt_valid (bkt_valid),
        .rd_bkt_head  (bkt_head),
        .rd_elem      (elem_idx),
        .rd_e_vpn     (e_vpn),
        .rd_e_pfn     (e_pfn),
        .rd_e_next    (e_next),
        .rd_e_last    (e_last)
    );

    hpt_walker #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .ELEM_W(ELEM_W), .MAX_WALK(MAX_WALK)
    ) u_walk (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vpn    (req_vpn),
        .req_ready  (req_ready),
        .busy       (busy),
        .vpn_q      (vpn_q),
        .bkt_valid  (bkt_valid),
        .bkt_head   (bkt_head),
        .elem_idx   (elem_idx),
        .e_vpn      (e_vpn),
        .e_pfn      (e_pfn),
        .e_next     (e_next),
        .e_last     (e_last),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_fault (resp_fault),
        .resp_pfn   (resp_pfn)
    );

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $onehot({resp_hit, resp_fault})) // R8
        else $error("response outcome not exclusive");
endmodule

// File: tb/tb_hpt_lookup.sv
module tb_hpt_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int VPN_W = 16;
    localparam int PFN_W = 12;
    localparam int BKT_W = 4;
    localparam int ELEM_W = 5;
    localparam int MAX_WALK = 8;
    localparam int ADDR_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic req_ready, resp_valid, resp_hit, resp_fault;
    logic [PFN_W-1:0] resp_pfn;
    logic wr_en = 1'b0, wr_is_elem = 1'b0, wr_flag = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic [PFN_W-1:0] wr_pfn = '0;
    logic [ELEM_W-1:0] wr_link = '0;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpt_lookup #(.VPN_W(VPN_W), .PFN_W(PFN_W), .BKT_W(BKT_W), .ELEM_W(ELEM_W),
                 .MAX_WALK(MAX_WALK)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_fault(resp_fault), .resp_pfn(resp_pfn), .wr_en(wr_en),
        .wr_is_elem(wr_is_elem), .wr_addr(wr_addr), .wr_vpn(wr_vpn),
        .wr_pfn(wr_pfn), .wr_link(wr_link), .wr_flag(wr_flag)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [BKT_W-1:0] fold(input logic [VPN_W-1:0] v);
        logic [BKT_W-1:0] h = '0;
        for (int i = 0; i < VPN_W; i++) h[i % BKT_W] ^= v[i];
        return h;
    endfunction

    task automatic tbl_write(input bit is_elem, input int addr, input logic [VPN_W-1:0] v,
                             input logic [PFN_W-1:0] p, input int link, input bit flag);
        @(negedge clk);
        wr_en = 1'b1; wr_is_elem = is_elem; wr_addr = ADDR_W'(addr);
        wr_vpn = v; wr_pfn = p; wr_link = ELEM_W'(link); wr_flag = flag;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [VPN_W-1:0] v, input bit exp_hit,
                          input logic [PFN_W-1:0] exp_pfn, input int exp_lat,
                          input string tag, input bit inject);
        int lat = 0;
        bit got = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, tag, "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_vpn = v;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9", "ready after accept", 32'(req_ready), 0);
        if (inject) begin
            wr_en = 1'b1; wr_is_elem = 1'b0; wr_addr = ADDR_W'(fold(v));
            wr_link = '0; wr_flag = 1'b0;
        end
        while (!got && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            wr_en = 1'b0;
            if (resp_valid) got = 1;
        end
        chk(got, tag, "response seen", 32'(got), 1);
        chk(lat == exp_lat, tag, "latency", 32'(lat), 32'(exp_lat));
        chk(resp_hit == exp_hit && resp_fault == !exp_hit, tag, "hit/fault",
            {30'd0, resp_hit, resp_fault}, {30'd0, exp_hit, !exp_hit});
        chk(resp_pfn == exp_pfn, tag, "frame", 32'(resp_pfn), 32'(exp_pfn));
        @(negedge clk);
        chk(resp_valid == 1'b0, "R8", "pulse width", 32'(resp_valid), 0);
        chk(req_ready == 1'b1, "R9", "ready after response", 32'(req_ready), 1);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1", "ready at reset", 32'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1", "no response at reset", 32'(resp_valid), 0);
        lookup(16'h1234, 0, '0, 1, "R1", 0);
    endtask

    task automatic t_chain;
        // bucket 4 chain: elem 3 -> 7 -> 9(last); all these page numbers fold to 4
        tbl_write(1, 3, 16'h1234, 12'hAAA, 7, 0);
        tbl_write(1, 7, 16'h0040, 12'hBBB, 9, 0);
        tbl_write(1, 9, 16'h4000, 12'hCCC, 0, 1);
        tbl_write(0, 4, '0, '0, 3, 1);
        lookup(16'h1234, 1, 12'hAAA, 2, "R3", 0);
        lookup(16'h0040, 1, 12'hBBB, 3, "R4", 0);
        lookup(16'h4000, 1, 12'hCCC, 4, "R4", 0);
        lookup(16'h0004, 0, '0, 4, "R6", 0);
    endtask

    task automatic t_hash;
        // 16'h5F00 folds to bucket A; 16'h5F01 folds to bucket B (empty)
        chk(fold(16'h5F00) == 4'hA, "R2", "bench fold", 32'(fold(16'h5F00)), 32'hA);
        tbl_write(1, 12, 16'h5F00, 12'h123, 0, 1);
        tbl_write(0, 10, '0, '0, 12, 1);
        lookup(16'h5F00, 1, 12'h123, 2, "R2", 0);
        lookup(16'h5F01, 0, '0, 1, "R5", 0);
    endtask

    task automatic t_loop;
        // bucket 2 -> elem 20 which links to itself, never marked last
        tbl_write(1, 20, 16'hFFFF, 12'h777, 20, 0);
        tbl_write(0, 2, '0, '0, 20, 1);
        lookup(16'h0002, 0, '0, MAX_WALK + 1, "R7", 0);
    endtask

    task automatic t_busy_write;
        // clear bucket 4 during a walk: must be ignored
        lookup(16'h4000, 1, 12'hCCC, 4, "R10", 1);
        lookup(16'h1234, 1, 12'hAAA, 2, "R10", 0);
        // same write while idle takes effect
        tbl_write(0, 4, '0, '0, 0, 0);
        lookup(16'h1234, 0, '0, 1, "R11", 0);
        // element rewrite while idle takes effect
        tbl_write(1, 12, 16'h5F00, 12'h456, 0, 1);
        lookup(16'h5F00, 1, 12'h456, 2, "R11", 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_chain();
        t_hash();
        t_loop();
        t_busy_write();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule